// File: doc/BRIEF.md
# Saturating Q15 to Unsigned Byte Packer

This datapath unit takes two 32-bit source words. It reads each as a pair of signed Q15 fractional halfwords and reduces each of the four halfwords to an unsigned 8-bit value, clamping where needed. The four bytes are packed into one 32-bit word, which is sign-extended from its top byte to give a 64-bit result.

The reduction is deliberately asymmetric:
- Any negative halfword becomes 0x00.
- A positive halfword whose 15-bit magnitude exceeds 0x7F80 becomes 0xFF.
- Every other halfword yields its magnitude bits 14..7, with the sign dropped and the low seven bits truncated.

Any clamp sets a sticky status bit at position 22 of a 32-bit control word. Software may read, write or clear that control word.

An operation is issued by holding `issue_i` high for one cycle; there is no handshake. The result register and the control word update on that clock edge.

Top module: `q15_ubyte_pack`

## Requirements
- R1: Lane A is `src_lo_i[15:0]`, lane B is `src_lo_i[31:16]`, lane C is `src_hi_i[15:0]` and lane D is `src_hi_i[31:16]`. In the packed word, lane A sits in bits 7:0, B in 15:8, C in 23:16 and D in 31:24.
- R2: A halfword with bit 15 clear and a magnitude (bits 14:0) of at most 0x7F80 yields magnitude bits 14:7. The low seven bits are dropped with no rounding, and the lane does not count as clamped.
- R3: A halfword with bit 15 clear and a magnitude above 0x7F80 yields 0xFF and counts as clamped. A magnitude of exactly 0x7F80 yields 0xFF and does not count as clamped.
- R4: A halfword with bit 15 set yields 0x00 and counts as clamped, whatever its magnitude.
- R5: Bits 63:32 of `result_o` all equal bit 31 of the packed word.
- R6: `result_o` is loaded on the clock edge at which `issue_i` is high, and holds its value on every edge where `issue_i` is low.
- R7: Bit 22 of the control word becomes 1 on the edge of an issue in which any lane clamps. It stays 1 until it is written or cleared; an issue with no clamp leaves it unchanged.
- R8: On an edge with `ctl_wr_i` high, the control word takes `ctl_wdata_i`. On an edge with `ctl_clr_i` high, it becomes zero, and clear wins over write. In every case, bit 22 is then ORed with that edge's clamp indication.
- R9: Synchronous active-high `rst` sets `result_o` and the control word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Start one conversion this cycle |
| src_hi_i | input | 32 | Source supplying lanes D and C |
| src_lo_i | input | 32 | Source supplying lanes B and A |
| result_o | output | 64 | Registered, sign-extended packed bytes |
| ctl_wr_i | input | 1 | Load the control word from `ctl_wdata_i` |
| ctl_wdata_i | input | 32 | Control word write data |
| ctl_clr_i | input | 1 | Zero the control word |
| ctl_rdata_o | output | 32 | Current control word (bit 22 is the clamp flag) |

## Verification
The bench targets the clamp boundary at 0x7F80 and 0x7F81. A design that uses greater-or-equal there would set the flag for 0x7F80, and one that rounds would give a different byte for magnitudes such as 0x00FF.

Negative inputs with a small magnitude (0xFFFF) and with the most negative value (0x8000) catch designs that saturate by magnitude instead of by sign.

Same-cycle collisions of a clamping issue with a write or clear of bit 22 show whether a design lets the write wipe out the new clamp. Idle cycles with changing operands show whether a design fails to hold its registered result.

// File: rtl/q15_ubyte_pack_pkg.sv
package q15_ubyte_pack_pkg;
  localparam int HALF_W  = 16;
  localparam int OUT_W   = 8;
  localparam int SRC_W   = 32;
  localparam int CTL_W   = 32;
  localparam int FLAG_IX = 22;
endpackage

// File: rtl/q15_ubyte_lane.sv
module q15_ubyte_lane #(
  parameter int HALF_W = 16,
  parameter int OUT_W  = 8
) (
  input  logic [HALF_W-1:0] half_i,
  output logic [OUT_W-1:0]  byte_o,
  output logic              clamp_o
);
  localparam int MAG_W = HALF_W - 1;
  localparam int CUT_W = MAG_W - OUT_W;
  localparam logic [MAG_W-1:0] SAT_LIM = {{OUT_W{1'b1}}, {CUT_W{1'b0}}};

  logic             neg;
  logic [MAG_W-1:0] mag;

  assign neg = half_i[HALF_W-1];
  assign mag = half_i[MAG_W-1:0];

  always_comb begin
    if (neg) begin
      byte_o  = '0;
      clamp_o = 1'b1;
    end else if (mag > SAT_LIM) begin
      byte_o  = '1;
      clamp_o = 1'b1;
    end else begin
      byte_o  = mag[MAG_W-1:CUT_W];
      clamp_o = 1'b0;
    end
  end
endmodule

// File: rtl/q15_ubyte_result_reg.sv
module q15_ubyte_result_reg #(
  parameter int PACK_W = 32,
  parameter int DST_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PACK_W-1:0] packed_i,
  output logic [DST_W-1:0]  result_o
);
  localparam int EXT_W = DST_W - PACK_W;

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else if (load_i) result_o <= {{EXT_W{packed_i[PACK_W-1]}}, packed_i};
  end
endmodule

// File: rtl/q15_ubyte_ctl_reg.sv
module q15_ubyte_ctl_reg #(
  parameter int CTL_W   = 32,
  parameter int FLAG_IX = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             clr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             set_flag_i,
  output logic [CTL_W-1:0] rdata_o
);
  logic [CTL_W-1:0] base;

  always_comb begin
    if (clr_i)     base = '0;
    else if (wr_i) base = wdata_i;
    else           base = rdata_o;
    base[FLAG_IX] = base[FLAG_IX] | set_flag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= base;
  end
endmodule

// File: rtl/q15_ubyte_pack.sv
module q15_ubyte_pack
  import q15_ubyte_pack_pkg::*;
#(
  parameter int DST_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic [SRC_W-1:0] src_hi_i,
  input  logic [SRC_W-1:0] src_lo_i,
  output logic [DST_W-1:0] result_o,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             ctl_clr_i,
  output logic [CTL_W-1:0] ctl_rdata_o
);
  localparam int LANES  = (2 * SRC_W) / HALF_W;
  localparam int PACK_W = LANES * OUT_W;

  logic [2*SRC_W-1:0] halves;
  logic [PACK_W-1:0]  packed_bytes;
  logic [LANES-1:0]   lane_clamp;
  logic               any_clamp;

  assign halves = {src_hi_i, src_lo_i};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    q15_ubyte_lane #(.HALF_W(HALF_W), .OUT_W(OUT_W)) u_lane (
      .half_i  (halves[i*HALF_W +: HALF_W]),
      .byte_o  (packed_bytes[i*OUT_W +: OUT_W]),
      .clamp_o (lane_clamp[i])
    );
  end

  assign any_clamp = issue_i & (|lane_clamp);

  q15_ubyte_result_reg #(.PACK_W(PACK_W), .DST_W(DST_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .load_i   (issue_i),
    .packed_i (packed_bytes),
    .result_o (result_o)
  );

  q15_ubyte_ctl_reg #(.CTL_W(CTL_W), .FLAG_IX(FLAG_IX)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (ctl_wr_i),
    .clr_i      (ctl_clr_i),
    .wdata_i    (ctl_wdata_i),
    .set_flag_i (any_clamp),
    .rdata_o    (ctl_rdata_o)
  );

  // R4: negative lane A gives a zero low byte
  a_r4_neg_lane_zero: assert property (@(posedge clk) disable iff (rst)
    (issue_i && src_lo_i[HALF_W-1]) |=> (result_o[OUT_W-1:0] == '0));

  // R7: negative lane D always raises the flag
  a_r7_clamp_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (issue_i && src_hi_i[SRC_W-1]) |=> ctl_rdata_o[FLAG_IX]);

  // R7: flag stays up without write or clear
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata_o[FLAG_IX] && !ctl_wr_i && !ctl_clr_i) |=> ctl_rdata_o[FLAG_IX]);

  // R6: result holds while idle
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> $stable(result_o));

  // R8: clear with no issue empties the control word
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl_clr_i && !issue_i) |=> (ctl_rdata_o == '0));

  // R5: upper half mirrors bit 31 of the packed word
  a_r5_sign_ext: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> (result_o[DST_W-1:PACK_W] == {(DST_W-PACK_W){result_o[PACK_W-1]}}));
endmodule

// File: tb/q15_ubyte_pack_tb.sv
module q15_ubyte_pack_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue_i;
  logic [31:0] src_hi_i, src_lo_i;
  logic [63:0] result_o;
  logic        ctl_wr_i, ctl_clr_i;
  logic [31:0] ctl_wdata_i, ctl_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] q_res[$];
  logic [31:0] q_ctl[$];
  string       q_tag[$];

  logic [63:0] exp_res = '0;
  logic [31:0] exp_ctl = '0;

  always #2.5 clk = ~clk;

  q15_ubyte_pack u_dut (
    .clk(clk), .rst(rst), .issue_i(issue_i),
    .src_hi_i(src_hi_i), .src_lo_i(src_lo_i), .result_o(result_o),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .ctl_clr_i(ctl_clr_i), .ctl_rdata_o(ctl_rdata_o)
  );

  function automatic logic [8:0] ref_lane(input logic [15:0] h);
    // returns {clamp, byte}
    if (h[15]) return {1'b1, 8'h00};
    if (h[14:0] > 15'h7F80) return {1'b1, 8'hFF};
    return {1'b0, h[14:7]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit iss, input logic [31:0] hi, input logic [31:0] lo,
                       input bit wr, input logic [31:0] wd, input bit clr, input string tag);
    logic [8:0] la, lb, lc, ld;
    logic       clamp;
    logic [31:0] pk;
    @(negedge clk);
    issue_i = iss; src_hi_i = hi; src_lo_i = lo;
    ctl_wr_i = wr; ctl_wdata_i = wd; ctl_clr_i = clr;
    la = ref_lane(lo[15:0]);  lb = ref_lane(lo[31:16]);
    lc = ref_lane(hi[15:0]);  ld = ref_lane(hi[31:16]);
    pk = {ld[7:0], lc[7:0], lb[7:0], la[7:0]};
    clamp = iss && (la[8] | lb[8] | lc[8] | ld[8]);
    if (iss) exp_res = {{32{pk[31]}}, pk};
    if (clr) exp_ctl = '0;
    else if (wr) exp_ctl = wd;
    exp_ctl[22] = exp_ctl[22] | clamp;
    q_res.push_back(exp_res);
    q_ctl.push_back(exp_ctl);
    q_tag.push_back(tag);
  endtask

  task automatic conv(input logic [31:0] hi, input logic [31:0] lo, input string tag);
    drive(1'b1, hi, lo, 1'b0, 32'h0, 1'b0, tag);
  endtask

  // Scoreboard monitor: compares one item per cycle just after the edge
  always @(posedge clk) begin
    #1;
    if (q_res.size() > 0) begin
      logic [63:0] er;
      logic [31:0] ec;
      string       t;
      er = q_res.pop_front();
      ec = q_ctl.pop_front();
      t  = q_tag.pop_front();
      check({t, " result"}, result_o, er);
      check({t, " ctl"}, {32'h0, ctl_rdata_o}, {32'h0, ec});
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; issue_i = 0; src_hi_i = 0; src_lo_i = 0;
    ctl_wr_i = 0; ctl_wdata_i = 0; ctl_clr_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset result", result_o, 64'h0);
    check("R9 reset ctl", {32'h0, ctl_rdata_o}, 64'h0);
    rst = 1'b0;

    // R1 lane mapping with distinct in-range values; R2 truncation path
    conv(32'h1000_2080, 32'h0080_3FFF, "R1 lane order");
    conv(32'h007F_00FF, 32'h0001_0100, "R2 truncate no round");
    // R3 boundary at 0x7F80 and just above
    conv(32'h0000_0000, 32'h0000_7F80, "R3 exact limit no flag");
    conv(32'h0000_0000, 32'h0000_7F81, "R3 above limit clamps");
    // R7 sticky: a clean issue keeps the flag
    conv(32'h1234_0100, 32'h0200_0300, "R7 flag sticky");
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, "R8 clear");
    // R4 negative values
    conv(32'h0000_0000, 32'h0000_FFFF, "R4 small negative");
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, "R8 clear again");
    conv(32'h0000_8000, 32'h0000_0000, "R4 most negative");
    // R5 sign extension: top byte 0xFF and 0x7F
    conv(32'h7F80_0000, 32'h0000_0000, "R5 sign ones");
    conv(32'h3F80_0000, 32'h0000_0000, "R5 sign zeros");
    // R6 hold with changing operands while idle
    drive(1'b0, 32'h8000_8000, 32'h8000_8000, 1'b0, 32'h0, 1'b0, "R6 hold 1");
    drive(1'b0, 32'h0100_0100, 32'h7FFF_7FFF, 1'b0, 32'h0, 1'b0, "R6 hold 2");
    // R8 write/clear interplay
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'hA5A5_5A5A, 1'b0, "R8 write all bits");
    drive(1'b1, 32'h8000_0000, 32'h0, 1'b1, 32'h0000_1234, 1'b0, "R8 write with clamp OR");
    drive(1'b1, 32'h0100_0100, 32'h0, 1'b1, 32'h0040_0000, 1'b0, "R8 write no clamp");
    drive(1'b1, 32'h0100_0100, 32'h0, 1'b1, 32'hFFBF_FFFF, 1'b0, "R8 write clears flag");
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 1'b1, "R8 clear beats write");
    drive(1'b1, 32'h0, 32'h0000_8000, 1'b0, 32'h0, 1'b1, "R8 clear with clamp");
    // R2/R3 mixed pattern across all lanes
    conv(32'h7F7F_7FFF, 32'h4000_0000, "R3 mixed lanes");
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, "R6 idle tail");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule